// File: doc/BRIEF.md
# Hash Job Register Controller

This block is the register front end of a hashing accelerator that computes SHA-1, SHA-256, HMAC-SHA-1 and HMAC-SHA-256. It is reached over a simple single-cycle 32-bit register bus with word addressing. It holds the job configuration, the HMAC key, the chaining value, the padding length and the fetch address and size. It forwards all of these to a compression datapath. A single write to the control word starts a job. The datapath answers with a done pulse that carries eight digest words, and the block captures them into read-only registers.

The block also owns the interrupt logic: a two-bit write-one-to-clear status gated by a two-bit enable onto one interrupt line. It also owns a soft reset that clears itself. While the soft reset runs, the block holds an engine reset output high for a fixed number of cycles. It then drops it and reports the reset as complete.

Top module: `hash_job_regs`

## Requirements
- R1: After rst_n is released, every register reads 0, and irq, eng_rst and job_start are 0.
- R2: Writing control (word 0) with bit 0 set starts a soft reset. Control bit 0 and eng_rst read 1 for exactly RST_CYCLES cycles after the write edge and then read 0. The soft reset aborts an active job (control bit 1 reads 0), clears both status bits and clears the stored control fields.
- R3: Writing control with bit 1 set and bit 0 clear, while idle and not resetting, launches a job. job_start is high for exactly the one cycle after the write edge. Control bit 1 reads 1 until done. job_mode follows bits 5:4 (0 SHA-1, 1 SHA-256, 2 HMAC-SHA-1, 3 HMAC-SHA-256), job_use_iv follows bit 8 and job_autopad follows bit 13. The upper fields read back as written.
- R4: job_ipad follows control bit 21 and job_opad follows bit 22, but only when mode bit 5 is 1 (HMAC). Otherwise both are 0.
- R5: A job_done pulse while busy clears busy and sets status bit 0. When it lands in the same cycle as a write of 1 to status bit 0, the set wins.
- R6: A launch write while busy is ignored. It sets status bit 1, and the control fields and job outputs keep their values.
- R7: The digest registers (words 32 to 39) load only on job_done while busy, and they ignore bus writes. In SHA-1 modes (mode bit 4 = 0), words 5 to 7 capture 0. A done pulse while idle changes nothing.
- R8: Status (word 1) is write-one-to-clear. A 1 clears the matching bit and a 0 leaves it unchanged.
- R9: irq is high exactly when some status bit and the matching enable bit (word 2, bits 1:0) are both 1.
- R10: The fetch address (word 4) reads back and is forwarded with bits 1:0 forced to 0. Bits 31:2 are kept as written.
- R11: Pad length (word 3), transfer size (word 5), IV words 8 to 15 and key words 16 to 31 read back as written. Word i of IV or key appears on job_iv or job_key at bits 32i+31:32i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_word_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word_addr |
| irq | output | 1 | Interrupt line |
| eng_rst | output | 1 | Engine reset, held during soft reset |
| job_start | output | 1 | One-cycle job launch pulse |
| job_mode | output | 2 | Hash mode |
| job_use_iv | output | 1 | Start from the IV registers |
| job_autopad | output | 1 | Pad the final block |
| job_ipad | output | 1 | HMAC inner key processing |
| job_opad | output | 1 | HMAC outer key processing |
| job_pad_len | output | 32 | Total message length in bytes |
| job_src_addr | output | 32 | Word-aligned fetch address |
| job_xfer_len | output | 32 | Transfer size in bytes |
| job_iv | output | 256 | Chaining value words |
| job_key | output | 512 | HMAC key block |
| job_done | input | 1 | Datapath completion pulse |
| job_digest | input | 256 | Digest words from the datapath |

## Verification
The hardest situation to reach is a completion pulse that coincides with a software clear of the same status bit. The bench reaches it by driving the done pulse and a status write in the same cycle right after a launch. The second hard case is a launch that collides with a job that is still busy. The bench sets this up with a second launch before the stub answers, then checks the error flag and that the control fields did not change. Random jobs cover all four modes and the flag combinations, with random digests and enables.

// File: rtl/hash_job_regs.sv
module hash_job_regs #(
  parameter int RST_CYCLES = 8,
  parameter int NUM_IV     = 8,
  parameter int NUM_KEY    = 16,
  parameter int NUM_DIG    = 8,
  parameter int SHA1_WORDS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [5:0]            bus_word_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq,
  output logic                  eng_rst,
  output logic                  job_start,
  output logic [1:0]            job_mode,
  output logic                  job_use_iv,
  output logic                  job_autopad,
  output logic                  job_ipad,
  output logic                  job_opad,
  output logic [31:0]           job_pad_len,
  output logic [31:0]           job_src_addr,
  output logic [31:0]           job_xfer_len,
  output logic [32*NUM_IV-1:0]  job_iv,
  output logic [32*NUM_KEY-1:0] job_key,
  input  logic                  job_done,
  input  logic [32*NUM_DIG-1:0] job_digest
);
  localparam int CW       = $clog2(RST_CYCLES + 1);
  localparam int IVW      = $clog2(NUM_IV);
  localparam int KYW      = $clog2(NUM_KEY);
  localparam int DGW      = $clog2(NUM_DIG);
  localparam int W_CTRL   = 0;
  localparam int W_STAT   = 1;
  localparam int W_EN     = 2;
  localparam int W_PAD    = 3;
  localparam int W_SRC    = 4;
  localparam int W_LEN    = 5;
  localparam int IV_BASE  = 8;
  localparam int KEY_BASE = 16;
  localparam int DIG_BASE = 32;

  logic [31:0]               ctrl_q, pad_q, src_q, len_q;
  logic [1:0]                stat_q, en_q;
  logic                      busy_q;
  logic [CW-1:0]             rst_cnt;
  logic [NUM_IV-1:0][31:0]   iv_q;
  logic [NUM_KEY-1:0][31:0]  key_q;
  logic [NUM_DIG-1:0][31:0]  dig_q;
  logic [31:0]               dig_cap [NUM_DIG];

  wire rst_act    = (rst_cnt != '0);
  wire wr_ctrl    = bus_wr && (bus_word_addr == 6'(W_CTRL));
  wire do_rst     = wr_ctrl && bus_wdata[0];
  wire launch_try = wr_ctrl && !bus_wdata[0] && bus_wdata[1];
  wire launch_ok  = launch_try && !busy_q && !rst_act;
  wire launch_err = launch_try && busy_q;
  wire ctrl_upd   = wr_ctrl && !bus_wdata[0] && !busy_q && !rst_act;
  wire done_ok    = job_done && busy_q && !do_rst;
  wire sha1_mode  = !ctrl_q[4];
  wire [1:0] w1c  = (bus_wr && bus_word_addr == 6'(W_STAT)) ? bus_wdata[1:0] : 2'b00;

  genvar g;
  generate
    for (g = 0; g < NUM_DIG; g++) begin : g_cap
      if (g >= SHA1_WORDS) begin : g_masked
        assign dig_cap[g] = sha1_mode ? 32'h0 : job_digest[32*g +: 32];
      end else begin : g_plain
        assign dig_cap[g] = job_digest[32*g +: 32];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      en_q      <= '0;
      busy_q    <= 1'b0;
      rst_cnt   <= '0;
      job_start <= 1'b0;
      dig_q     <= '0;
    end else begin
      job_start <= launch_ok;
      if (do_rst) begin
        rst_cnt <= CW'(RST_CYCLES);
        busy_q  <= 1'b0;
        stat_q  <= '0;
        ctrl_q  <= '0;
      end else begin
        if (rst_act) rst_cnt <= rst_cnt - 1'b1;
        if (launch_ok) busy_q <= 1'b1;
        else if (done_ok) busy_q <= 1'b0;
        if (ctrl_upd) ctrl_q <= {bus_wdata[31:2], 2'b00};
        stat_q <= (stat_q & ~w1c) | {launch_err, done_ok};
      end
      if (bus_wr && bus_word_addr == 6'(W_EN)) en_q <= bus_wdata[1:0];
      if (done_ok)
        for (int i = 0; i < NUM_DIG; i++) dig_q[i] <= dig_cap[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
      src_q <= '0;
      len_q <= '0;
      iv_q  <= '0;
      key_q <= '0;
    end else if (bus_wr) begin
      if (bus_word_addr == 6'(W_PAD)) pad_q <= bus_wdata;
      if (bus_word_addr == 6'(W_SRC)) src_q <= {bus_wdata[31:2], 2'b00};
      if (bus_word_addr == 6'(W_LEN)) len_q <= bus_wdata;
      for (int i = 0; i < NUM_IV; i++)
        if (bus_word_addr == 6'(IV_BASE + i)) iv_q[i] <= bus_wdata;
      for (int i = 0; i < NUM_KEY; i++)
        if (bus_word_addr == 6'(KEY_BASE + i)) key_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    int idx;
    idx = int'(bus_word_addr);
    bus_rdata = '0;
    if (idx == W_CTRL)      bus_rdata = {ctrl_q[31:2], busy_q, rst_act};
    else if (idx == W_STAT) bus_rdata = {30'b0, stat_q};
    else if (idx == W_EN)   bus_rdata = {30'b0, en_q};
    else if (idx == W_PAD)  bus_rdata = pad_q;
    else if (idx == W_SRC)  bus_rdata = src_q;
    else if (idx == W_LEN)  bus_rdata = len_q;
    else if (idx >= IV_BASE && idx < IV_BASE + NUM_IV) begin
      idx = idx - IV_BASE;
      bus_rdata = iv_q[idx[IVW-1:0]];
    end else if (idx >= KEY_BASE && idx < KEY_BASE + NUM_KEY) begin
      idx = idx - KEY_BASE;
      bus_rdata = key_q[idx[KYW-1:0]];
    end else if (idx >= DIG_BASE && idx < DIG_BASE + NUM_DIG) begin
      idx = idx - DIG_BASE;
      bus_rdata = dig_q[idx[DGW-1:0]];
    end
  end

  assign irq          = |(stat_q & en_q);
  assign eng_rst      = rst_act;
  assign job_mode     = ctrl_q[5:4];
  assign job_use_iv   = ctrl_q[8];
  assign job_autopad  = ctrl_q[13];
  assign job_ipad     = ctrl_q[21] & ctrl_q[5];
  assign job_opad     = ctrl_q[22] & ctrl_q[5];
  assign job_pad_len  = pad_q;
  assign job_src_addr = src_q;
  assign job_xfer_len = len_q;
  assign job_iv       = iv_q;
  assign job_key      = key_q;

  AST_RST_ABORTS:    assert property (@(posedge clk) disable iff (!rst_n) do_rst |=> (!busy_q && eng_rst && stat_q == 2'b00)); // R2
  AST_START_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) job_start |=> !job_start); // R3
  AST_START_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) job_start |-> busy_q); // R3
  AST_HMAC_GATE:     assert property (@(posedge clk) disable iff (!rst_n) !job_mode[1] |-> !(job_ipad || job_opad)); // R4
  AST_DONE_SETS:     assert property (@(posedge clk) disable iff (!rst_n) done_ok |=> (stat_q[0] && !busy_q)); // R5
  AST_BUSY_ERROR:    assert property (@(posedge clk) disable iff (!rst_n) (launch_try && busy_q) |=> stat_q[1]); // R6
  AST_DIGEST_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(dig_q) |-> $past(job_done && busy_q)); // R7
  AST_IRQ_MASKED:    assert property (@(posedge clk) disable iff (!rst_n) (en_q == 2'b00) |-> !irq); // R9
  AST_SRC_ALIGNED:   assert property (@(posedge clk) disable iff (!rst_n) job_src_addr[1:0] == 2'b00); // R10
endmodule

// File: tb/sim_hash_job_regs.sv
`timescale 1ns/1ps
module sim_hash_job_regs;
  localparam int RSTC = 8;
  localparam logic [5:0] A_CTRL = 6'd0, A_STAT = 6'd1, A_EN = 6'd2, A_PAD = 6'd3,
                         A_SRC = 6'd4, A_LEN = 6'd5, A_IV = 6'd8, A_KEY = 6'd16, A_DIG = 6'd32;

  logic clk = 0, rst_n = 0, bus_wr = 0, job_done = 0;
  logic [5:0] bus_word_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, eng_rst, job_start, job_use_iv, job_autopad, job_ipad, job_opad;
  logic [1:0] job_mode;
  logic [31:0] job_pad_len, job_src_addr, job_xfer_len;
  logic [255:0] job_iv, job_digest = 0;
  logic [511:0] job_key;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  hash_job_regs #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_rst(eng_rst),
    .job_start(job_start), .job_mode(job_mode), .job_use_iv(job_use_iv),
    .job_autopad(job_autopad), .job_ipad(job_ipad), .job_opad(job_opad),
    .job_pad_len(job_pad_len), .job_src_addr(job_src_addr), .job_xfer_len(job_xfer_len),
    .job_iv(job_iv), .job_key(job_key), .job_done(job_done), .job_digest(job_digest));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_word_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_word_addr = a; #1; d = bus_rdata;
  endtask

  task automatic done(input logic [255:0] dg);
    job_done = 1; job_digest = dg;
    @(negedge clk);
    job_done = 0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [1:0] m, input logic iv, ap, ip, op);
    logic [31:0] w = 0;
    w[1] = 1; w[5:4] = m; w[8] = iv; w[12] = 1; w[13] = ap; w[21] = ip; w[22] = op;
    return w;
  endfunction

  function automatic logic [31:0] exp_dig(input logic [1:0] m, input int i, input logic [255:0] dg);
    return (!m[0] && i >= 5) ? 32'h0 : dg[32*i +: 32];
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r, w, w2, v;
    logic [255:0] dg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    rd(A_STAT, r); chk("R1 stat", r, 0);
    rd(A_DIG, r);  chk("R1 digest", r, 0);
    rd(A_KEY, r);  chk("R1 key", r, 0);
    chk("R1 outs", {irq, eng_rst, job_start}, 0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] m; logic iv, ap, ip, op, en;
      m = 2'($urandom); iv = 1'($urandom); ap = 1'($urandom);
      ip = 1'($urandom); op = 1'($urandom); en = 1'($urandom);
      w = ctrl_word(m, iv, ap, ip, op);
      wr(A_CTRL, w);
      chk("R3 start", {31'b0, job_start}, 1);
      chk("R3 mode", {30'b0, job_mode}, {30'b0, m});
      chk("R3 flags", {30'b0, job_use_iv, job_autopad}, {30'b0, iv, ap});
      chk("R4 hmac", {30'b0, job_ipad, job_opad}, {30'b0, ip & m[1], op & m[1]});
      rd(A_CTRL, r); chk("R3 readback", r, w);
      @(negedge clk);
      chk("R3 one cycle", {31'b0, job_start}, 0);
      wr(A_EN, {31'b0, en});
      for (int i = 0; i < 8; i++) dg[32*i +: 32] = $urandom;
      done(dg);
      rd(A_STAT, r); chk("R5 status", r, 1);
      chk("R9 irq", {31'b0, irq}, {31'b0, en});
      rd(A_CTRL, r); chk("R5 idle", r & 3, 0);
      for (int i = 0; i < 8; i++) begin
        rd(A_DIG + 6'(i), r); chk("R7 digest", r, exp_dig(m, i, dg));
      end
      wr(A_STAT, 1);
      rd(A_STAT, r); chk("R8 clear", r, 0);
      v = $urandom;
      case (n % 5)
        0: begin wr(A_PAD, v); rd(A_PAD, r); chk("R11 pad", r, v); chk("R11 pad out", job_pad_len, v); end
        1: begin wr(A_LEN, v); rd(A_LEN, r); chk("R11 len", r, v); chk("R11 len out", job_xfer_len, v); end
        2: begin wr(A_SRC, v); rd(A_SRC, r); chk("R10 src", r, {v[31:2], 2'b00});
                 chk("R10 src out", job_src_addr, {v[31:2], 2'b00}); end
        3: begin int k = n % 8; wr(A_IV + 6'(k), v); rd(A_IV + 6'(k), r);
                 chk("R11 iv", r, v); chk("R11 iv out", job_iv[32*k +: 32], v); end
        default: begin int k = n % 16; wr(A_KEY + 6'(k), v); rd(A_KEY + 6'(k), r);
                 chk("R11 key", r, v); chk("R11 key out", job_key[32*k +: 32], v); end
      endcase
    end

    // R6: collision with a busy job
    wr(A_EN, 0);
    w  = ctrl_word(2'd3, 1, 1, 1, 1);
    w2 = ctrl_word(2'd0, 0, 0, 0, 0);
    wr(A_CTRL, w);
    wr(A_CTRL, w2);
    rd(A_STAT, r); chk("R6 error flag", r, 2);
    rd(A_CTRL, r); chk("R6 fields kept", r, w);
    chk("R6 mode kept", {30'b0, job_mode}, 3);
    chk("R6 no start", {31'b0, job_start}, 0);
    wr(A_EN, 2); chk("R9 irq err", {31'b0, irq}, 1);
    wr(A_EN, 1); chk("R9 irq masked", {31'b0, irq}, 0);

    // R2: soft reset while busy
    wr(A_CTRL, 1);
    for (int i = 0; i < RSTC; i++) begin
      rd(A_CTRL, r); chk("R2 reset bit", r, 1);
      chk("R2 eng_rst", {31'b0, eng_rst}, 1);
      @(negedge clk);
    end
    rd(A_CTRL, r); chk("R2 reset done", r, 0);
    chk("R2 eng_rst low", {31'b0, eng_rst}, 0);
    rd(A_STAT, r); chk("R2 status cleared", r, 0);

    // R5: done and clear in the same cycle
    w = ctrl_word(2'd1, 0, 1, 0, 0);
    wr(A_CTRL, w);
    dg = {8{32'hA5A5_0F0F}};
    job_done = 1; job_digest = dg;
    bus_wr = 1; bus_word_addr = A_STAT; bus_wdata = 3;
    @(negedge clk);
    job_done = 0; bus_wr = 0;
    rd(A_STAT, r); chk("R5 set wins", r, 1);
    rd(A_DIG + 6'd7, r); chk("R7 sha256 word7", r, 32'hA5A5_0F0F);

    // R7: idle done and bus writes leave the digest alone
    wr(A_STAT, 3);
    done({8{32'h1234_5678}});
    rd(A_DIG, r); chk("R7 idle done", r, 32'hA5A5_0F0F);
    rd(A_STAT, r); chk("R7 idle status", r, 0);
    wr(A_DIG + 6'd2, 32'hDEAD_BEEF);
    rd(A_DIG + 6'd2, r); chk("R7 read only", r, 32'hA5A5_0F0F);

    // R8: partial clear
    wr(A_CTRL, ctrl_word(2'd0, 0, 0, 0, 0));
    wr(A_CTRL, ctrl_word(2'd0, 0, 0, 0, 0));
    done({8{32'h0000_0001}});
    rd(A_STAT, r); chk("R8 both set", r, 3);
    wr(A_STAT, 2); rd(A_STAT, r); chk("R8 clear bit1", r, 1);
    wr(A_STAT, 0); rd(A_STAT, r); chk("R8 zero keeps", r, 1);
    wr(A_STAT, 1); rd(A_STAT, r); chk("R8 clear bit0", r, 0);
    rd(A_DIG + 6'd5, r); chk("R7 sha1 word5", r, 0);

    summary();
  end
endmodule